// File: doc/BRIEF.md
# Load-Store Address and Data Unit

This unit carries out the memory half of byte, half-word and word loads and stores for a 32-bit core. Decode hands it a single issue request. The request holds the operation kind, the access size, the addressing mode, a general-register base, the element-pointer value, a raw 16-bit displacement field and the store data. The unit forms the effective address and clears the low address bits so that every access is naturally aligned. It then presents one request on a single-port memory interface with per-byte enables.

Stores finish once the memory accepts the request. Loads wait for a read-valid strobe. The unit then selects the addressed lane of the returned word, sign-extends it and presents it for register write-back with a one-cycle done pulse. Addressing takes one of two forms. The pointer-relative form adds a small zero-extended offset to the element pointer. The register-relative form adds a sign-extended 16-bit offset to a general register. Misaligned addresses are never trapped: they are rounded down to the access size. Address sums wrap silently at 2^32.

Top module: `lsu_unit`

## Requirements
- R1: In pointer-relative mode (`issue_short`=1) with byte size, only `disp_raw[6:0]` is used, zero-extended and added to `ep_val`. Bits 15..7 of the field have no effect.
- R2: In pointer-relative mode with half-word or word size, only `disp_raw[7:0]` is used, zero-extended and added to `ep_val`.
- R3: In register-relative mode (`issue_short`=0), `disp_raw` is sign-extended from bit 15 and added to `base_reg`.
- R4: Half-word accesses drive `mem_addr[0]`=0. Word accesses drive `mem_addr[1:0]`=0. This holds for loads and stores alike.
- R5: `mem_be` is 4'b0001<<addr[1:0] for a byte (size 2'b00). It is 4'b0011 or 4'b1100 for a half-word (size 2'b01), chosen by addr[1]. It is 4'b1111 for a word (size 2'b10 or 2'b11). Byte lane k is bits 8k+7..8k, little-endian.
- R6: On a store, `mem_wdata` carries the low byte of `store_data` in all four lanes for a byte, the low half-word in both halves for a half-word, and the full word for a word.
- R7: On a load, the byte or half-word lane picked by the low address bits is sign-extended to 32 bits on `wb_data`. A word is passed through unchanged.
- R8: `mem_req_valid` rises in the cycle after issue, with `mem_we`=1 for a store. Address, enables and data stay unchanged until the cycle in which `mem_req_ready` is high.
- R9: `done` is high for exactly one cycle. For a store, this is the cycle after acceptance. For a load, it is the cycle after `mem_rvalid`, with `wb_data` valid in that same cycle.
- R10: `busy` is high from the cycle after issue up to and excluding the done cycle. `issue_valid` has no effect while `busy` is high.
- R11: Address sums wrap modulo 2^32 without any fault.
- R12: After reset, `busy`, `mem_req_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Issue strobe, taken only when idle |
| issue_store | input | 1 | 1 = store, 0 = load |
| issue_size | input | 2 | 00 byte, 01 half-word, 10/11 word |
| issue_short | input | 1 | 1 = pointer-relative, 0 = register-relative |
| base_reg | input | 32 | General-register base |
| ep_val | input | 32 | Element-pointer value |
| disp_raw | input | 16 | Raw displacement field |
| store_data | input | 32 | Source register value for stores |
| busy | output | 1 | Access in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Aligned byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | 32 | Read data word |
| done | output | 1 | One-cycle completion pulse |
| wb_data | output | 32 | Extended load result |

## Verification
The bench drives inputs on the falling edge and samples one falling edge after each event, so every result is read one cycle after the edge that registers it. The request fields are due one cycle after issue. Store completion is due one cycle after the cycle in which ready is high. Load completion and write-back data are due one cycle after the read-valid strobe. Each check waits exactly that many cycles. Reference addresses, enables, lane data and extended results are computed by bench functions, and random latencies stretch the hold and wait phases between those fixed points.

// File: rtl/lsu_pkg.sv
// Shared types for the load-store unit.
// Assumes a 32-bit little-endian data path of four byte lanes.
package lsu_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WRD2 = 2'b11
    } lsu_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_REQ  = 2'b01,
        ST_WAIT = 2'b10
    } lsu_state_e;
endpackage

// File: rtl/lsu_agen.sv
// Effective address generation with forced natural alignment.
// Pointer-relative mode zero-extends a short offset (width depends on size);
// register-relative mode sign-extends the full field. Sums wrap freely.
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DISP_W  = 16,
    parameter int SB_W    = 7,
    parameter int SHW_W   = 8
) (
    input  logic              short_mode,
    input  lsu_size_e         size,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] ep,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] addr
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] sum;

    // Select and extend the displacement for the active mode.
    always_comb begin
        if (short_mode) begin
            if (size == SZ_BYTE) offset = ADDR_W'(disp[SB_W-1:0]);
            else                 offset = ADDR_W'(disp[SHW_W-1:0]);
        end else begin
            offset = {{EXT_W{disp[DISP_W-1]}}, disp};
        end
    end

    assign sum = (short_mode ? ep : base) + offset;

    // Round the address down to the access size.
    always_comb begin
        unique case (size)
            SZ_BYTE: addr = sum;
            SZ_HALF: addr = {sum[ADDR_W-1:1], 1'b0};
            default: addr = {sum[ADDR_W-1:2], 2'b00};
        endcase
    end
endmodule

// File: rtl/lsu_lanes.sv
// Store-side lane steering: byte enables and replicated write data.
// Assumes the address is already aligned to the access size.
module lsu_lanes
    import lsu_pkg::*;
#(
    parameter int LANES = 4
) (
    input  lsu_size_e           size,
    input  logic [1:0]          addr_lo,
    input  logic [8*LANES-1:0]  sdata,
    output logic [LANES-1:0]    be,
    output logic [8*LANES-1:0]  wdata
);
    localparam int HALVES = LANES / 2;

    // Compute enables and replicate the source into every lane.
    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                be    = LANES'(1) << addr_lo;
                wdata = {LANES{sdata[7:0]}};
            end
            SZ_HALF: begin
                be    = addr_lo[1] ? LANES'(4'b1100) : LANES'(4'b0011);
                wdata = {HALVES{sdata[15:0]}};
            end
            default: begin
                be    = '1;
                wdata = sdata;
            end
        endcase
    end
endmodule

// File: rtl/lsu_extract.sv
// Load-side lane selection and sign extension to register width.
// Assumes the address low bits are the aligned ones of the request.
module lsu_extract
    import lsu_pkg::*;
#(
    parameter int LANES = 4
) (
    input  lsu_size_e           size,
    input  logic [1:0]          addr_lo,
    input  logic [8*LANES-1:0]  rdata,
    output logic [8*LANES-1:0]  result
);
    localparam int DW = 8 * LANES;

    logic [7:0]  lane [LANES];
    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    // Split the read word into byte lanes.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane[k] = rdata[8*k +: 8];
    end

    assign sel_b = lane[addr_lo];
    assign sel_h = addr_lo[1] ? {lane[3], lane[2]} : {lane[1], lane[0]};

    // Extend the selected lane to full width.
    always_comb begin
        unique case (size)
            SZ_BYTE: result = {{(DW-8){sel_b[7]}}, sel_b};
            SZ_HALF: result = {{(DW-16){sel_h[15]}}, sel_h};
            default: result = rdata;
        endcase
    end
endmodule

// File: rtl/lsu_unit.sv
// Load-store unit top: latches one access on issue, holds the memory
// request until accepted, waits for read data on loads, and pulses done.
// Assumes memory returns exactly one read-valid per accepted load.
module lsu_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int LANES  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    input  logic                 issue_store,
    input  logic [1:0]           issue_size,
    input  logic                 issue_short,
    input  logic [ADDR_W-1:0]    base_reg,
    input  logic [ADDR_W-1:0]    ep_val,
    input  logic [DISP_W-1:0]    disp_raw,
    input  logic [8*LANES-1:0]   store_data,
    output logic                 busy,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [LANES-1:0]     mem_be,
    output logic [8*LANES-1:0]   mem_wdata,
    input  logic                 mem_rvalid,
    input  logic [8*LANES-1:0]   mem_rdata,
    output logic                 done,
    output logic [8*LANES-1:0]   wb_data
);
    localparam int DW = 8 * LANES;

    lsu_state_e        state;
    lsu_size_e         in_size;
    lsu_size_e         r_size;
    logic [ADDR_W-1:0] ea;
    logic [LANES-1:0]  be_c;
    logic [DW-1:0]     wd_c;
    logic [DW-1:0]     ld_c;

    assign in_size = lsu_size_e'(issue_size);

    lsu_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) i_agen (
        .short_mode (issue_short),
        .size       (in_size),
        .base       (base_reg),
        .ep         (ep_val),
        .disp       (disp_raw),
        .addr       (ea)
    );

    lsu_lanes #(.LANES(LANES)) i_lanes (
        .size    (in_size),
        .addr_lo (ea[1:0]),
        .sdata   (store_data),
        .be      (be_c),
        .wdata   (wd_c)
    );

    lsu_extract #(.LANES(LANES)) i_extract (
        .size    (r_size),
        .addr_lo (mem_addr[1:0]),
        .rdata   (mem_rdata),
        .result  (ld_c)
    );

    // Sequence one access: issue, request hold, read wait, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            r_size    <= SZ_BYTE;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_be    <= '0;
            mem_wdata <= '0;
            done      <= 1'b0;
            wb_data   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (issue_valid) begin
                    state     <= ST_REQ;
                    r_size    <= in_size;
                    mem_we    <= issue_store;
                    mem_addr  <= ea;
                    mem_be    <= be_c;
                    mem_wdata <= wd_c;
                end
                ST_REQ: if (mem_req_ready) begin
                    if (mem_we) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: if (mem_rvalid) begin
                    state   <= ST_IDLE;
                    done    <= 1'b1;
                    wb_data <= ld_c;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy          = (state != ST_IDLE);
    assign mem_req_valid = (state == ST_REQ);
endmodule

// File: rtl/lsu_unit_chk.sv
// Protocol checker for lsu_unit, attached by bind.
// Observes only top-level ports.
module lsu_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic [31:0] mem_wdata,
    input logic        done
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) && $stable(mem_be) && $stable(mem_wdata) && $stable(mem_we)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !mem_req_valid); // R10
    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy); // R10
    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_be == 4'h1 || mem_be == 4'h2 || mem_be == 4'h4 || mem_be == 4'h8 || mem_be == 4'h3 || mem_be == 4'hC || mem_be == 4'hF)); // R5
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_be == 4'hF |-> mem_addr[1:0] == 2'b00); // R4
    AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && $countones(mem_be) == 2 |-> mem_addr[0] == 1'b0); // R4
endmodule

bind lsu_unit lsu_unit_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_be        (mem_be),
    .mem_wdata     (mem_wdata),
    .done          (done)
);

// File: tb/test_lsu_unit.sv
`timescale 1ns/1ps
// Bench for lsu_unit: directed corners plus seeded random accesses
// against a behavioural word memory.
module test_lsu_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0, issue_store = 1'b0, issue_short = 1'b0;
    logic [1:0]  issue_size = 2'b00;
    logic [31:0] base_reg = '0, ep_val = '0, store_data = '0;
    logic [15:0] disp_raw = '0;
    logic        mem_req_ready = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, mem_req_valid, mem_we, done;
    logic [31:0] mem_addr, mem_wdata, wb_data;
    logic [3:0]  mem_be;

    logic [31:0] model [64];
    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lsu_unit i_lsu_unit (.*);

    // Record one check; print a FAIL line on mismatch.
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] f_addr(input bit sh, input logic [1:0] sz,
                                           input logic [31:0] b, input logic [31:0] e, input logic [15:0] d);
        logic [31:0] s;
        if (sh) s = e + ((sz == 2'b00) ? {25'd0, d[6:0]} : {24'd0, d[7:0]});
        else    s = b + {{16{d[15]}}, d};
        if (sz == 2'b01) s[0] = 1'b0;
        else if (sz[1])  s[1:0] = 2'b00;
        return s;
    endfunction

    function automatic logic [3:0] f_be(input logic [1:0] sz, input logic [1:0] lo);
        if (sz == 2'b00) return 4'b0001 << lo;
        if (sz == 2'b01) return lo[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] f_wd(input logic [1:0] sz, input logic [31:0] sd);
        if (sz == 2'b00) return {4{sd[7:0]}};
        if (sz == 2'b01) return {2{sd[15:0]}};
        return sd;
    endfunction

    function automatic logic [31:0] f_ld(input logic [1:0] sz, input logic [1:0] lo, input logic [31:0] rd);
        logic [7:0]  b;
        logic [15:0] h;
        b = rd[8*lo +: 8];
        h = lo[1] ? rd[31:16] : rd[15:0];
        if (sz == 2'b00) return {{24{b[7]}}, b};
        if (sz == 2'b01) return {{16{h[15]}}, h};
        return rd;
    endfunction

    // Run one access end to end and check every due result.
    task automatic run_op(input bit st, input bit sh, input logic [1:0] sz,
                          input logic [31:0] b, input logic [31:0] e, input logic [15:0] d,
                          input logic [31:0] sd, input int hold, input int lat, input string atag);
        logic [31:0] ea, wd, rd;
        logic [3:0]  be;
        ea = f_addr(sh, sz, b, e, d);
        be = f_be(sz, ea[1:0]);
        wd = f_wd(sz, sd);
        @(negedge clk);
        issue_valid = 1'b1; issue_store = st; issue_short = sh; issue_size = sz;
        base_reg = b; ep_val = e; disp_raw = d; store_data = sd;
        @(negedge clk);
        issue_valid = 1'b0;
        chk(busy == 1'b1, "R10 busy after issue", 32'(busy), 32'd1);
        chk(mem_req_valid == 1'b1 && mem_we == st, "R8 request", {mem_req_valid, mem_we}, {1'b1, st});
        chk(mem_addr == ea, atag, mem_addr, ea);
        chk(mem_addr[1:0] == ea[1:0], "R4 alignment", 32'(mem_addr[1:0]), 32'(ea[1:0]));
        chk(mem_be == be, "R5 byte enables", 32'(mem_be), 32'(be));
        if (st) chk(mem_wdata == wd, "R6 store lanes", mem_wdata, wd);
        for (int i = 0; i < hold; i++) begin
            if (i == 0) begin
                issue_valid = 1'b1; issue_store = ~st; issue_short = ~sh;
                base_reg = ~b; ep_val = ~e; disp_raw = ~d; store_data = ~sd;
            end
            @(negedge clk);
            issue_valid = 1'b0;
            chk(mem_req_valid && mem_addr == ea && mem_be == be, "R8 hold until ready", mem_addr, ea);
            chk(mem_we == st, "R10 issue ignored while busy", 32'(mem_we), 32'(st));
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (st) begin
            chk(done == 1'b1, "R9 store done", 32'(done), 32'd1);
            chk(busy == 1'b0, "R10 busy clears at done", 32'(busy), 32'd0);
            for (int k = 0; k < 4; k++)
                if (be[k]) model[ea[7:2]][8*k +: 8] = wd[8*k +: 8];
        end else begin
            chk(done == 1'b0 && busy == 1'b1, "R9 load waits", {done, busy}, 32'b01);
            repeat (lat) @(negedge clk);
            rd = model[ea[7:2]];
            mem_rvalid = 1'b1; mem_rdata = rd;
            @(negedge clk);
            mem_rvalid = 1'b0; mem_rdata = ~rd;
            chk(done == 1'b1, "R9 load done", 32'(done), 32'd1);
            chk(wb_data == f_ld(sz, ea[1:0], rd), "R7 load extension", wb_data, f_ld(sz, ea[1:0], rd));
        end
        @(negedge clk);
        chk(done == 1'b0, "R9 single pulse", 32'(done), 32'd0);
        chk(busy == 1'b0 && mem_req_valid == 1'b0, "R10 idle after done", {busy, mem_req_valid}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd24680));
        for (int i = 0; i < 64; i++) model[i] = 32'h0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && mem_req_valid == 1'b0 && done == 1'b0, "R12 reset state",
            {busy, mem_req_valid, done}, 32'd0);
        rst_n = 1'b1;
        // Directed corners.
        run_op(1, 1, 2'b11, 0, 32'h0000_0100, 16'hFF84, 32'h80FF_7F01, 0, 0, "R2 short word");
        run_op(0, 1, 2'b00, 0, 32'h0000_0100, 16'hFF84, 0, 2, 1, "R1 short byte ignores upper disp");
        run_op(0, 1, 2'b00, 0, 32'h0000_0100, 16'h0087, 0, 0, 0, "R1 short byte lane 3");
        run_op(0, 1, 2'b01, 0, 32'h0000_0100, 16'h0087, 0, 1, 2, "R2 short half forced even");
        run_op(0, 0, 2'b10, 32'h0000_0107, 0, 16'hFFFF, 0, 0, 0, "R3 negative displacement");
        run_op(1, 1, 2'b00, 0, 32'hFFFF_FFF0, 16'h0013, 32'h0000_00AB, 1, 0, "R11 pointer wrap");
        run_op(0, 0, 2'b00, 32'hFFFF_FFF0, 0, 16'h0013, 0, 0, 3, "R11 register wrap");
        run_op(1, 0, 2'b01, 32'h0000_8004, 0, 16'h8000, 32'h1234_C0DE, 2, 0, "R3 most negative offset");
        // Seeded random accesses.
        for (int n = 0; n < 400; n++) begin
            bit sh, st;
            logic [1:0] sz;
            sh = 1'($urandom);
            st = 1'($urandom);
            sz = 2'($urandom % 3);
            run_op(st, sh, sz, $urandom, $urandom, 16'($urandom), $urandom,
                   int'($urandom % 4), int'($urandom % 4),
                   sh ? ((sz == 2'b00) ? "R1 random address" : "R2 random address") : "R3 random address");
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog expired actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule